// File: doc/BRIEF.md
# Next-Fetch-Address Predictor

This block sits in the fetch stage of a pipelined core. In the same cycle that a fetch address arrives, it answers two questions: will the instruction at that address redirect fetch, and if so, where to. When it predicts no redirect, it returns the sequential address (fetch address plus 4). Three tables produce the answer. The first is a direct-mapped target buffer. Each entry holds the full address of a branch, the kind of branch, and the most recent target seen for it. The second is a table of 2-bit direction counters for conditional branches. The third is a return-address stack that supplies targets for subroutine returns.

All three tables are trained only from a resolve-side update port. That port reports the branch address, its kind, whether it was taken, and the target it actually went to. A prediction lookup reads the contents held before the current clock edge. An update issued in a given cycle becomes visible from the next cycle on. The stack is pushed and popped only by resolved calls and returns, so it holds no speculative state and needs no recovery.

Kind encoding on every kind field: 0 = conditional, 1 = jump, 2 = call, 3 = return.

Top module: `nfa_predictor`

## Requirements
- R1: After reset, no target-buffer entry is valid, every lookup predicts not taken with next address fetch_pc+4, and every direction counter holds 1 (weakly not taken).
- R2: A resolved branch reported as taken writes the buffer entry at index pc[IDX_W+1:2], storing the full branch address as tag, the kind and the target. A later taken resolution of the same branch replaces the stored target with the newer one.
- R3: A resolved branch reported as not taken never writes the target buffer, so it cannot create a redirect.
- R4: A redirect requires the fetch address to equal the stored tag in every bit. A different address that maps to the same index predicts not taken with fetch_pc+4.
- R5: Each conditional branch uses a 2-bit counter at index pc[BHT_IDX_W+1:2]. A resolved taken branch increments the counter and a resolved not-taken branch decrements it, saturating at 3 and 0. A conditional entry that hits redirects only when its counter is 2 or 3.
- R6: A resolved call pushes its address plus 4 onto the stack. A buffer hit on a return entry takes its target from the stack top, not from the stored target. A resolved return pops the stack.
- R7: The stack holds RAS_DEPTH (32) entries. Its occupancy saturates at RAS_DEPTH. A push into a full stack wraps the pointer and overwrites the oldest entry.
- R8: When the stack is empty, a return hit predicts not taken with fetch_pc+4. A pop on an empty stack changes nothing, and a stack that has become empty restarts at slot zero.
- R9: When a lookup and an update touch the same entry in the same cycle, the lookup sees the old contents. The update is visible from the next cycle on.
- R10: A hit on a jump or call entry always redirects to the stored target, whatever the value of the direction counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | Current fetch address |
| pred_taken | output | 1 | Prediction: fetch redirects |
| pred_next | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_kind | input | 2 | Kind of the resolved branch (0 cond, 1 jump, 2 call, 3 return) |
| upd_taken | input | 1 | Actual outcome |
| upd_target | input | PC_W | Actual target |

## Verification
The assertions check four things on every cycle. A redirect only happens when the indexed buffer entry is valid. A not-taken prediction always yields the sequential address. Not-taken updates leave the valid bits unchanged. Stack occupancy grows by exactly one on each non-full call and never exceeds its depth. Other behaviours need the bench's ordered scenarios. These are the counter saturation walk, exact-tag aliasing, rewriting a target with a newer one, the same-cycle old-contents rule, and the stack's wrap-and-drain sequence. Each of them shows up only as a specific next address after a chosen history of updates.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  typedef enum logic [1:0] {
    BR_COND = 2'd0,
    BR_JUMP = 2'd1,
    BR_CALL = 2'd2,
    BR_RET  = 2'd3
  } br_kind_e;
endpackage

// File: rtl/nfa_target_buf.sv
module nfa_target_buf
  import nfa_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PC_W-1:0]        rd_pc,
  output logic                   rd_hit,
  output br_kind_e               rd_kind,
  output logic [PC_W-1:0]        rd_tgt,
  input  logic                   wr_en,
  input  logic [PC_W-1:0]        wr_pc,
  input  br_kind_e               wr_kind,
  input  logic [PC_W-1:0]        wr_tgt,
  output logic [(1<<IDX_W)-1:0]  vld_vec
);
  localparam int N = 1 << IDX_W;

  logic [PC_W-1:0] tag_mem  [N];
  logic [PC_W-1:0] tgt_mem  [N];
  br_kind_e        kind_mem [N];
  logic [N-1:0]    vld_q;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  assign rd_idx = rd_pc[IDX_W+1:2];
  assign wr_idx = wr_pc[IDX_W+1:2];

  // data arrays: no reset, single write port, asynchronous read
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_pc;
      tgt_mem[wr_idx]  <= wr_tgt;
      kind_mem[wr_idx] <= wr_kind;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  assign rd_hit  = vld_q[rd_idx] && (tag_mem[rd_idx] == rd_pc);
  assign rd_kind = kind_mem[rd_idx];
  assign rd_tgt  = tgt_mem[rd_idx];
  assign vld_vec = vld_q;
endmodule

// File: rtl/nfa_dir_table.sv
module nfa_dir_table #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_taken,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic            wr_taken
);
  localparam int N = 1 << IDX_W;
  localparam logic [1:0] CTR_INIT = 2'd1;

  logic [1:0]       ctr_q [N];
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [1:0]       cur, nxt;

  assign rd_idx = rd_pc[IDX_W+1:2];
  assign wr_idx = wr_pc[IDX_W+1:2];
  assign cur    = ctr_q[wr_idx];

  always_comb begin
    nxt = cur;
    if (wr_taken && cur != 2'd3)       nxt = cur + 2'd1;
    else if (!wr_taken && cur != 2'd0) nxt = cur - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) ctr_q[i] <= CTR_INIT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= nxt;
    end
  end

  assign rd_taken = ctr_q[rd_idx][1];
endmodule

// File: rtl/nfa_ret_stack.sv
module nfa_ret_stack #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  logic [PC_W-1:0]                push_addr,
  input  logic                           pop,
  output logic                           top_valid,
  output logic [PC_W-1:0]                top_addr,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PC_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] sp_q, top_idx, sp_inc;
  logic [CNT_W-1:0] cnt_q;

  assign sp_inc  = (sp_q == LAST) ? '0 : sp_q + 1'b1;
  assign top_idx = (sp_q == '0) ? LAST : sp_q - 1'b1;

  always_ff @(posedge clk) begin
    if (push) mem[sp_q] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= '0;
      cnt_q <= '0;
    end else if (push) begin
      sp_q <= sp_inc;
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end else if (pop && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      sp_q  <= (cnt_q == CNT_W'(1)) ? '0 : top_idx;
    end
  end

  assign top_valid = (cnt_q != '0);
  assign top_addr  = mem[top_idx];
  assign count     = cnt_q;
endmodule

// File: rtl/nfa_predictor.sv
module nfa_predictor
  import nfa_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int BTB_IDX_W  = 4,
  parameter int BHT_IDX_W  = 6,
  parameter int RAS_DEPTH  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_next,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [1:0]      upd_kind,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  localparam int BTB_N = 1 << BTB_IDX_W;
  localparam int CNT_W = $clog2(RAS_DEPTH+1);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  br_kind_e         ukind;
  logic             hit, dir_t, ras_ok;
  br_kind_e         hkind;
  logic [PC_W-1:0]  htgt, ras_top;
  logic [BTB_N-1:0] btb_vld;
  logic [CNT_W-1:0] ras_cnt;

  assign ukind = br_kind_e'(upd_kind);

  nfa_target_buf #(.PC_W(PC_W), .IDX_W(BTB_IDX_W)) u_btb (
    .clk(clk), .rst(rst),
    .rd_pc(fetch_pc), .rd_hit(hit), .rd_kind(hkind), .rd_tgt(htgt),
    .wr_en(upd_valid && upd_taken), .wr_pc(upd_pc), .wr_kind(ukind),
    .wr_tgt(upd_target), .vld_vec(btb_vld)
  );

  nfa_dir_table #(.PC_W(PC_W), .IDX_W(BHT_IDX_W)) u_bht (
    .clk(clk), .rst(rst),
    .rd_pc(fetch_pc), .rd_taken(dir_t),
    .wr_en(upd_valid && ukind == BR_COND), .wr_pc(upd_pc),
    .wr_taken(upd_taken)
  );

  nfa_ret_stack #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk(clk), .rst(rst),
    .push(upd_valid && ukind == BR_CALL), .push_addr(upd_pc + STEP),
    .pop(upd_valid && ukind == BR_RET),
    .top_valid(ras_ok), .top_addr(ras_top), .count(ras_cnt)
  );

  logic            take;
  logic [PC_W-1:0] tgt;

  always_comb begin
    take = 1'b0;
    tgt  = htgt;
    if (hit) begin
      unique case (hkind)
        BR_COND: take = dir_t;
        BR_JUMP,
        BR_CALL: take = 1'b1;
        BR_RET: begin
          take = ras_ok;
          tgt  = ras_top;
        end
        default: take = 1'b0;
      endcase
    end
  end

  assign pred_taken = take;
  assign pred_next  = take ? tgt : fetch_pc + STEP;
endmodule

// File: rtl/nfa_predictor_chk.sv
module nfa_predictor_chk #(
  parameter int PC_W      = 32,
  parameter int BTB_IDX_W = 4,
  parameter int RAS_DEPTH = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic [PC_W-1:0]               fetch_pc,
  input logic                          pred_taken,
  input logic [PC_W-1:0]               pred_next,
  input logic                          upd_valid,
  input logic [1:0]                    upd_kind,
  input logic                          upd_taken,
  input logic [(1<<BTB_IDX_W)-1:0]     btb_vld,
  input logic [$clog2(RAS_DEPTH+1)-1:0] ras_cnt
);
  localparam int CNT_W = $clog2(RAS_DEPTH+1);

  AST_CLEAN_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pred_taken); // R1

  AST_NOT_TAKEN_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    !pred_taken |-> pred_next == fetch_pc + PC_W'(4)); // R8

  AST_REDIRECT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> btb_vld[fetch_pc[BTB_IDX_W+1:2]]); // R4

  AST_NO_ALLOC_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken) |=> $stable(btb_vld)); // R3

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_kind == 2'd2 && ras_cnt != CNT_W'(RAS_DEPTH))
      |=> ras_cnt == $past(ras_cnt) + 1'b1); // R6

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (rst)
    ras_cnt <= CNT_W'(RAS_DEPTH)); // R7
endmodule

bind nfa_predictor nfa_predictor_chk #(
  .PC_W(PC_W), .BTB_IDX_W(BTB_IDX_W), .RAS_DEPTH(RAS_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
  .pred_next(pred_next), .upd_valid(upd_valid), .upd_kind(upd_kind),
  .upd_taken(upd_taken), .btb_vld(btb_vld), .ras_cnt(ras_cnt)
);

// File: tb/tb_nfa_predictor.sv
module tb_nfa_predictor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc = '0;
  logic        pred_taken;
  logic [31:0] pred_next;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [1:0]  upd_kind = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  localparam logic [1:0] K_COND = 2'd0, K_JUMP = 2'd1, K_CALL = 2'd2, K_RET = 2'd3;

  always #2.5 clk = ~clk;

  nfa_predictor dut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
    .pred_next(pred_next), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_kind(upd_kind), .upd_taken(upd_taken), .upd_target(upd_target)
  );

  typedef struct {
    logic        t;
    logic [31:0] n;
    string       r;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // drive one cycle: optional update plus a lookup with expected result
  task automatic cyc(input logic uv, input logic [1:0] uk, input logic ut,
                     input logic [31:0] upc, input logic [31:0] utg,
                     input logic [31:0] fpc, input logic et,
                     input logic [31:0] en, input string req);
    exp_t e;
    @(posedge clk); #1;
    upd_valid = uv; upd_kind = uk; upd_taken = ut;
    upd_pc = upd_valid ? upc : '0; upd_target = utg;
    fetch_pc = fpc;
    e.t = et; e.n = en; e.r = req;
    q.push_back(e);
  endtask

  task automatic upd(input logic [1:0] uk, input logic ut,
                     input logic [31:0] upc, input logic [31:0] utg);
    @(posedge clk); #1;
    upd_valid = 1'b1; upd_kind = uk; upd_taken = ut;
    upd_pc = upc; upd_target = utg; fetch_pc = '0;
  endtask

  task automatic look(input logic [31:0] fpc, input logic et,
                      input logic [31:0] en, input string req);
    cyc(1'b0, K_COND, 1'b0, '0, '0, fpc, et, en, req);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pred_taken !== e.t || pred_next !== e.n) begin
        fails++;
        $display("FAIL %s: taken=%0b next=%h, expected taken=%0b next=%h",
                 e.r, pred_taken, pred_next, e.t, e.n);
      end
    end
  end

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    look(32'h100, 1'b0, 32'h104, "R1 reset");
    look(32'h2A8, 1'b0, 32'h2AC, "R1 reset other pc");
    // R3: not-taken conditional does not allocate (counter 1 -> 0)
    upd(K_COND, 1'b0, 32'h100, 32'h200);
    look(32'h100, 1'b0, 32'h104, "R3 no alloc");
    // R5: taken allocates, counter 0 -> 1, still not taken
    upd(K_COND, 1'b1, 32'h100, 32'h200);
    look(32'h100, 1'b0, 32'h104, "R5 weak not taken");
    upd(K_COND, 1'b1, 32'h100, 32'h200);
    look(32'h100, 1'b1, 32'h200, "R2 R5 taken");
    // R4: alias on same index, different upper bits
    look(32'h140, 1'b0, 32'h144, "R4 alias");
    // R2: new target replaces old (counter 3)
    upd(K_COND, 1'b1, 32'h100, 32'h300);
    look(32'h100, 1'b1, 32'h300, "R2 rewrite");
    // R5: saturate at 3, then decrement twice
    upd(K_COND, 1'b1, 32'h100, 32'h300);
    upd(K_COND, 1'b0, 32'h100, 32'h0);
    look(32'h100, 1'b1, 32'h300, "R5 saturate");
    upd(K_COND, 1'b0, 32'h100, 32'h0);
    look(32'h100, 1'b0, 32'h104, "R5 decrement");
    // R9: same-cycle update sees old contents
    cyc(1'b1, K_COND, 1'b1, 32'h100, 32'h380, 32'h100, 1'b0, 32'h104, "R9 old contents");
    look(32'h100, 1'b1, 32'h380, "R9 next cycle");
    // R10: jump ignores weak counter
    upd(K_JUMP, 1'b1, 32'h20C, 32'h400);
    look(32'h20C, 1'b1, 32'h400, "R10 jump");
    // R8: return entry with empty stack
    upd(K_RET, 1'b1, 32'h310, 32'h999);
    look(32'h310, 1'b0, 32'h314, "R8 empty return");
    // R6: call push, return uses stack top
    upd(K_CALL, 1'b1, 32'h508, 32'h600);
    look(32'h310, 1'b1, 32'h50C, "R6 return from stack");
    look(32'h508, 1'b1, 32'h600, "R10 call");
    upd(K_RET, 1'b1, 32'h310, 32'h50C);
    look(32'h310, 1'b0, 32'h314, "R8 drained");
    // R7: 33 pushes wrap, oldest lost
    for (int k = 0; k < 33; k++) upd(K_CALL, 1'b1, 32'h101C + 32'(64*k), 32'h600);
    look(32'h310, 1'b1, 32'h1820, "R7 top after wrap");
    for (int k = 0; k < 31; k++) upd(K_RET, 1'b1, 32'h310, 32'h0);
    look(32'h310, 1'b1, 32'h1060, "R7 deepest survivor");
    upd(K_RET, 1'b1, 32'h310, 32'h0);
    look(32'h310, 1'b0, 32'h314, "R7 R8 empty after full drain");
    upd(K_RET, 1'b1, 32'h310, 32'h0);
    upd(K_CALL, 1'b1, 32'h508, 32'h600);
    look(32'h310, 1'b1, 32'h50C, "R8 restart after empty pop");
    @(posedge clk); #1 upd_valid = 1'b0;
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule